// File: doc/BRIEF.md
# Suspend Indicator Blink Generator

This block drives one indicator pin from a three-bit pattern code. Some codes hold the pin at a fixed level. The others make it toggle as a square wave at a fixed rate between 0.25 Hz and 4 Hz. The code occupies the upper three bits of a byte-wide configuration register. The lower five bits of that register hold unrelated settings, which the block stores and returns unchanged.

The register can be loaded in two ways. A full byte write replaces all eight bits. A pattern-only write replaces just the three code bits and keeps the other five. A single prescaler, sized from the clock-frequency parameter, gives a tick at the 4 Hz half period. All slower rates count whole multiples of that tick. When a write changes the code, the waveform restarts so that the new pattern opens with a complete high half period.

Top module: `susled_gen`

## Requirements
- R1: After reset the register reads 0x00 and `led_o` is 1.
- R2: A full write (`wr_en_i`=1) loads `wr_data_i` into all eight register bits. The new value is visible on `rd_data_o` after the clock edge that samples the write.
- R3: A pattern write (`mode_we_i`=1 with `wr_en_i`=0) puts `mode_i` into register bits 7:5 and keeps bits 4:0. If both write strobes are high in the same cycle, the full write takes effect.
- R4: Code 000 (bits 7:5) holds `led_o` at 1. Code 010 holds it at 0.
- R5: Each half period lasts CLK_HZ/(2·f) clock cycles. Code 001 blinks at 0.5 Hz, code 011 at 2 Hz, code 100 at 1 Hz and code 101 at 4 Hz.
- R6: Codes 110 and 111 both blink at 0.25 Hz.
- R7: Every blinking code has equal high and low half periods, repeated without drift.
- R8: Suppose the code is changed by a write sampled at edge E, and the new code is a blinking one. Then `led_o` is 1 from edge E+1 for one full half period of the new rate.
- R9: A write that leaves bits 7:5 unchanged does not restart the waveform. A write that changes only bits 4:0 has no effect on the timing of `led_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Full byte write strobe |
| wr_data_i | input | 8 | Full byte write data |
| mode_we_i | input | 1 | Pattern-only write strobe |
| mode_i | input | 3 | Pattern code for a pattern-only write |
| rd_data_o | output | 8 | Current register contents |
| led_o | output | 1 | Registered indicator output |

## Verification
The hardest case to reach is a rewrite that lands partway through a half period. Such a write either leaves the code unchanged, which must not restart the waveform, or changes it, which must restart it at once. The bench sets the clock parameter low, so each half period is a few hundred cycles. It issues each write a known number of cycles after a measured edge. It then counts the cycles in each following high or low run and compares the count with the cycle count the requirement predicts.

// File: rtl/susled_pkg.sv
package susled_pkg;
  typedef enum logic [2:0] {
    M_HIGH  = 3'b000,
    M_HALF  = 3'b001,
    M_LOW   = 3'b010,
    M_TWO   = 3'b011,
    M_ONE   = 3'b100,
    M_FOUR  = 3'b101,
    M_QTR_A = 3'b110,
    M_QTR_B = 3'b111
  } led_mode_e;

  localparam int unsigned UNIT_W = 5;

  // half period in units of the 4 Hz half period; 0 = steady level
  function automatic logic [UNIT_W-1:0] half_units(led_mode_e m);
    case (m)
      M_FOUR:           half_units = 5'd1;
      M_TWO:            half_units = 5'd2;
      M_ONE:            half_units = 5'd4;
      M_HALF:           half_units = 5'd8;
      M_QTR_A, M_QTR_B: half_units = 5'd16;
      default:          half_units = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/susled_reg.sv
module susled_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       mode_we_i,
  input  logic [2:0] mode_i,
  output logic [7:0] reg_o,
  output logic       chg_o
);
  logic [7:0] reg_q, reg_d;
  logic       chg_q;

  always_comb begin
    if (wr_en_i)        reg_d = wr_data_i;
    else if (mode_we_i) reg_d = {mode_i, reg_q[4:0]};
    else                reg_d = reg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= 8'h00;
      chg_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      chg_q <= (reg_d[7:5] != reg_q[7:5]);
    end
  end

  assign reg_o = reg_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/susled_prescale.sv
module susled_prescale #(
  parameter int unsigned HALF_CLKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q == LAST)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !restart_i;
endmodule

// File: rtl/susled_wave.sv
module susled_wave
  import susled_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  led_mode_e mode_i,
  input  logic      restart_i,
  input  logic      tick_i,
  output logic      led_o
);
  logic [UNIT_W-1:0] unit_q, span;
  logic              phase_q, blink;

  assign span  = half_units(mode_i);
  assign blink = (span != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q  <= '0;
      phase_q <= 1'b1;
    end else if (restart_i) begin
      unit_q  <= '0;
      phase_q <= (mode_i != M_LOW);
    end else if (tick_i && blink) begin
      if (unit_q == span - 1'b1) begin
        unit_q  <= '0;
        phase_q <= ~phase_q;
      end else begin
        unit_q  <= unit_q + 1'b1;
      end
    end
  end

  assign led_o = phase_q;
endmodule

// File: rtl/susled_gen.sv
module susled_gen
  import susled_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       mode_we_i,
  input  logic [2:0] mode_i,
  output logic [7:0] rd_data_o,
  output logic       led_o
);
  localparam int unsigned HALF_CLKS = CLK_HZ / 8;

  logic [7:0] reg_q;
  logic       mode_chg, tick;

  susled_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .mode_we_i, .mode_i,
    .reg_o(reg_q), .chg_o(mode_chg)
  );

  susled_prescale #(.HALF_CLKS(HALF_CLKS)) u_pre (
    .clk_i, .rst_ni, .restart_i(mode_chg), .tick_o(tick)
  );

  susled_wave u_wave (
    .clk_i, .rst_ni, .mode_i(led_mode_e'(reg_q[7:5])),
    .restart_i(mode_chg), .tick_i(tick), .led_o
  );

  assign rd_data_o = reg_q;
endmodule

// File: rtl/susled_chk.sv
module susled_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       mode_we_i,
  input logic [7:0] rd_data_o,
  input logic       led_o,
  input logic       restart
);
  p_full_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  p_low_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !wr_en_i) |=> rd_data_o[4:0] == $past(rd_data_o[4:0]));

  p_const_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7:5] == 3'b000 && $past(rd_data_o[7:5]) == 3'b000) |-> led_o);

  p_const_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7:5] == 3'b010 && $past(rd_data_o[7:5]) == 3'b010) |-> !led_o);

  p_restart_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && rd_data_o[7:5] != 3'b010 && !wr_en_i && !mode_we_i) |=> led_o);
endmodule

bind susled_gen susled_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .mode_we_i,
  .rd_data_o, .led_o, .restart(mode_chg)
);

// File: tb/sim_susled_gen.sv
`timescale 1ns/1ps
module sim_susled_gen;
  localparam int unsigned CLK_HZ = 800;
  localparam int unsigned HALF = CLK_HZ / 8;

  logic       clk = 0, rst_ni = 0;
  logic       wr_en_i = 0, mode_we_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] mode_i = '0;
  logic [7:0] rd_data_o;
  logic       led_o;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  susled_gen #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .mode_we_i, .mode_i,
    .rd_data_o, .led_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples n negedges; one check that all equal lvl
  task automatic hold(input bit lvl, input int n, input string req);
    int mism = 0, first = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (led_o !== lvl) begin
        mism++;
        if (first < 0) first = k;
      end
    end
    chk(mism == 0, req, first, -1);
  endtask

  // pattern write sampled at edge E; returns just after edge E+1
  task automatic pat_write(input logic [2:0] code);
    @(negedge clk); mode_we_i = 1; mode_i = code;
    @(negedge clk); mode_we_i = 0;
    @(posedge clk);
  endtask

  task automatic t_reset;
    chk(rd_data_o == 8'h00, "R1 reg", rd_data_o, 0);
    chk(led_o == 1'b1, "R1 led", led_o, 1);
  endtask

  task automatic t_full_write;
    @(negedge clk); wr_en_i = 1; wr_data_i = 8'h0B;
    @(negedge clk); wr_en_i = 0;
    chk(rd_data_o == 8'h0B, "R2 full write", rd_data_o, 8'h0B);
    hold(1'b1, 50, "R4 code 000 high");
  endtask

  task automatic t_blink(input logic [2:0] code, input int units, input string req);
    pat_write(code);
    chk(rd_data_o == {code, 5'h0B}, "R3 low bits kept", rd_data_o, {code, 5'h0B});
    for (int h = 0; h < 4; h++)
      hold(~h[0], units * HALF, (h == 0) ? "R8 restart high" : req);
  endtask

  task automatic t_same_code;
    int h = 16 * HALF;
    @(posedge clk);                 // rising edge of next high run
    hold(1'b1, 100, "R7 high run");
    wr_en_i = 1; wr_data_i = 8'hF5;
    @(negedge clk); wr_en_i = 0;
    chk(led_o == 1'b1, "R9 no restart", led_o, 1);
    chk(rd_data_o == 8'hF5, "R2 rewrite", rd_data_o, 8'hF5);
    hold(1'b1, h - 101, "R9 high run unchanged");
    hold(1'b0, h, "R9 low run unchanged");
  endtask

  task automatic t_const;
    pat_write(3'b010);
    hold(1'b0, 500, "R4 code 010 low");
    pat_write(3'b000);
    hold(1'b1, 500, "R4 code 000 high");
  endtask

  task automatic t_priority;
    @(negedge clk); wr_en_i = 1; wr_data_i = 8'h4C; mode_we_i = 1; mode_i = 3'b111;
    @(negedge clk); wr_en_i = 0; mode_we_i = 0;
    chk(rd_data_o == 8'h4C, "R3 full write wins", rd_data_o, 8'h4C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_blink(3'b001, 8, "R5 0.5Hz");
    t_blink(3'b011, 2, "R5 2Hz");
    t_blink(3'b100, 4, "R5 1Hz");
    t_blink(3'b101, 1, "R5 4Hz");
    t_blink(3'b110, 16, "R6 code 110");
    t_blink(3'b111, 16, "R6 code 111");
    t_same_code();
    t_const();
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule